// File: doc/BRIEF.md
# Serial Memory Write Guard

This block keeps the protection and status state of a serial nonvolatile memory of 2^ADDR_W bytes. An instruction engine that owns the serial shifting hands it one-cycle event pulses: write-enable with the bit count of its frame, write-disable, status write with its data byte, array write commit with its start address, and end of the internal write cycle. From these it keeps a write-enable latch, a busy flag, two block-protect bits and a protect-pin enable bit. It also presents the status byte that the engine shifts out on a status read.

Two combinational answers go back to the engine. The first says whether an array write to the address on `tgt_addr` would be taken now. The second says whether a status write would be taken now. The protect-pin enable bit gates the hardware lock pin, and that lock guards only the status bits. The array is guarded by the block-protect bits, which fence off a quarter, a half or all of the address space, always counted from the top. The block-protect and pin-enable bits stand for nonvolatile cells. A reset does not touch them, and parameters give their power-up values.

Top module: `spi_mem_guard`

## Requirements
- R1: `status_o` is {pin-enable bit at 7, zeros at 6..4, protect bits at 3..2, write-enable latch at 1, busy at 0}, valid on every cycle including while busy.
- R2: With protect code 00 no address is protected; with 01 the top quarter is protected (top two address bits 11); with 10 the top half (top bit 1); with 11 every address. `addr_ok` is 1 only when the latch is set, the block is not busy and `tgt_addr` is unprotected.
- R3: A write-enable event whose frame held exactly WREN_LEN bits sets the latch.
- R4: A write-enable event with any other bit count leaves the latch unchanged.
- R5: A write-disable event clears the latch in any protection or busy state. It wins over a write-enable event in the same cycle.
- R6: A commit with `addr_ok` high pulses `array_wr_go` for one cycle, sets busy and clears the latch.
- R7: A commit with `addr_ok` low is dropped. There is no pulse, and the latch and busy stay as they were.
- R8: A status write taken with `stat_ok` high loads bit 7 and bits 3..2 of `wrsr_byte`, ignores its other bits, sets busy and clears the latch.
- R9: The hardware lock holds when `lock_pin_n` is low and the pin-enable bit is 1. While it holds, `stat_ok` is 0 and a status write changes nothing, not even the latch. With the pin high or the enable bit 0, status writes are allowed.
- R10: Busy stays set until a write-done event clears it. A change on `lock_pin_n` during that time has no effect on the write under way.
- R11: Reset clears the latch and busy but keeps the protect and pin-enable bits. At power-up those bits take INIT_BP and INIT_WPEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lock_pin_n | input | 1 | Hardware lock pin, low requests the lock |
| ev_wren | input | 1 | Write-enable instruction ended (frame closed) |
| wren_bits | input | CNT_W | Bits clocked in the write-enable frame |
| ev_wrdi | input | 1 | Write-disable instruction decoded |
| ev_wrsr | input | 1 | Status write frame completed |
| wrsr_byte | input | 8 | Data byte of the status write |
| ev_wr_commit | input | 1 | Array write frame completed |
| tgt_addr | input | ADDR_W | Start address for query and commit |
| ev_wr_done | input | 1 | Internal write cycle finished |
| status_o | output | 8 | Status byte |
| addr_ok | output | 1 | Array write to `tgt_addr` would be taken |
| stat_ok | output | 1 | Status write would be taken |
| array_wr_go | output | 1 | One-cycle start of an accepted array write |

## Verification
The bench probes the address boundaries of each protect code on both sides, for example the last free and the first fenced byte of the quarter and half settings. A wrong decode shows there as `addr_ok` set on a fenced byte or cleared on a free one. It sends write-enable frames one bit short and one bit long. A design that ignored the bit count would set the latch on those. It attempts status writes under the pin lock with the pin-enable bit set, and again with it clear. A design that cleared the latch on a refused write, or applied the lock without the enable bit, would show a wrong status byte. It moves the lock pin in the middle of a busy period and pulses reset after protection has been programmed. A design that aborted the write, or reset the retained bits, would lose busy early or read back protect code 00.

// File: rtl/spi_mem_guard.sv
module spi_mem_guard #(
  parameter int          ADDR_W    = 11,
  parameter int          CNT_W     = 6,
  parameter int          WREN_LEN  = 8,
  parameter logic [1:0]  INIT_BP   = 2'b00,
  parameter logic        INIT_WPEN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_pin_n,
  input  logic              ev_wren,
  input  logic [CNT_W-1:0]  wren_bits,
  input  logic              ev_wrdi,
  input  logic              ev_wrsr,
  input  logic [7:0]        wrsr_byte,
  input  logic              ev_wr_commit,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic              ev_wr_done,
  output logic [7:0]        status_o,
  output logic              addr_ok,
  output logic              stat_ok,
  output logic              array_wr_go
);
  localparam int QTOP = ADDR_W - 1;

  logic       wel_q, wip_q, go_q;
  logic [1:0] bp_q   = INIT_BP;
  logic       wpen_q = INIT_WPEN;
  logic [1:0] quarter;
  logic       fenced, ready, hw_lock, take_sr, take_wr, wren_ok;

  assign quarter = tgt_addr[QTOP -: 2];

  always_comb begin
    case (bp_q)
      2'b00:   fenced = 1'b0;
      2'b01:   fenced = &quarter;
      2'b10:   fenced = quarter[1];
      default: fenced = 1'b1;
    endcase
  end

  assign ready   = wel_q & ~wip_q;
  assign hw_lock = wpen_q & ~lock_pin_n;
  assign addr_ok = ready & ~fenced;
  assign stat_ok = ready & ~hw_lock;
  assign take_sr = ev_wrsr & stat_ok;
  assign take_wr = ev_wr_commit & addr_ok & ~ev_wrsr;
  assign wren_ok = ev_wren & (wren_bits == CNT_W'(WREN_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
      wip_q <= 1'b0;
      go_q  <= 1'b0;
    end else begin
      go_q <= take_wr;
      if (take_sr | take_wr)   wip_q <= 1'b1;
      else if (ev_wr_done)     wip_q <= 1'b0;
      if (ev_wrdi | take_sr | take_wr) wel_q <= 1'b0;
      else if (wren_ok)                wel_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take_sr) begin
      wpen_q <= wrsr_byte[7];
      bp_q   <= wrsr_byte[3:2];
    end
  end

  assign status_o    = {wpen_q, 3'b000, bp_q, wel_q, wip_q};
  assign array_wr_go = go_q;
endmodule

// File: rtl/spi_mem_guard_chk.sv
module spi_mem_guard_chk #(
  parameter int CNT_W    = 6,
  parameter int WREN_LEN = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lock_pin_n,
  input logic             ev_wren,
  input logic [CNT_W-1:0] wren_bits,
  input logic             ev_wrdi,
  input logic             ev_wrsr,
  input logic             ev_wr_commit,
  input logic             ev_wr_done,
  input logic [7:0]       status_o,
  input logic             addr_ok,
  input logic             array_wr_go
);
  a_r3_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wren && wren_bits == CNT_W'(WREN_LEN) && !ev_wrdi && !ev_wrsr && !ev_wr_commit
    |=> status_o[1]);

  a_r4_wren_len: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wren && wren_bits != CNT_W'(WREN_LEN) && !ev_wrdi && !ev_wrsr && !ev_wr_commit
    |=> $stable(status_o[1]));

  a_r5_wrdi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrdi |=> !status_o[1]);

  a_r6_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_commit && addr_ok && !ev_wrsr |=> array_wr_go && status_o[0] && !status_o[1]);

  a_r7_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_commit && !addr_ok |=> !array_wr_go);

  a_r9_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrsr && status_o[7] && !lock_pin_n |=> $stable(status_o[7:1]));

  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] && !ev_wr_done |=> status_o[0]);

  always @(posedge clk) begin
    if (!rst_n) a_r11_reset_clears: assert (status_o[1:0] == 2'b00);
  end
endmodule

bind spi_mem_guard spi_mem_guard_chk #(.CNT_W(CNT_W), .WREN_LEN(WREN_LEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .lock_pin_n(lock_pin_n), .ev_wren(ev_wren),
  .wren_bits(wren_bits), .ev_wrdi(ev_wrdi), .ev_wrsr(ev_wrsr),
  .ev_wr_commit(ev_wr_commit), .ev_wr_done(ev_wr_done), .status_o(status_o),
  .addr_ok(addr_ok), .array_wr_go(array_wr_go)
);

// File: tb/spi_mem_guard_tb_top.sv
module spi_mem_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lock_pin_n = 1'b1;
  logic        ev_wren = 1'b0, ev_wrdi = 1'b0, ev_wrsr = 1'b0;
  logic        ev_wr_commit = 1'b0, ev_wr_done = 1'b0;
  logic [5:0]  wren_bits = '0;
  logic [7:0]  wrsr_byte = '0;
  logic [10:0] tgt_addr = '0;
  logic [7:0]  status_o;
  logic        addr_ok, stat_ok, array_wr_go;
  int          n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  spi_mem_guard dut_i (
    .clk(clk), .rst_n(rst_n), .lock_pin_n(lock_pin_n), .ev_wren(ev_wren),
    .wren_bits(wren_bits), .ev_wrdi(ev_wrdi), .ev_wrsr(ev_wrsr),
    .wrsr_byte(wrsr_byte), .ev_wr_commit(ev_wr_commit), .tgt_addr(tgt_addr),
    .ev_wr_done(ev_wr_done), .status_o(status_o), .addr_ok(addr_ok),
    .stat_ok(stat_ok), .array_wr_go(array_wr_go)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wren(input logic [5:0] bits);
    @(negedge clk); ev_wren = 1'b1; wren_bits = bits;
    @(negedge clk); ev_wren = 1'b0;
  endtask
  task automatic wrdi();
    @(negedge clk); ev_wrdi = 1'b1;
    @(negedge clk); ev_wrdi = 1'b0;
  endtask
  task automatic wrsr(input logic [7:0] b);
    @(negedge clk); ev_wrsr = 1'b1; wrsr_byte = b;
    @(negedge clk); ev_wrsr = 1'b0;
  endtask
  task automatic commit(input logic [10:0] a);
    @(negedge clk); ev_wr_commit = 1'b1; tgt_addr = a;
    @(negedge clk); ev_wr_commit = 1'b0;
  endtask
  task automatic done();
    @(negedge clk); ev_wr_done = 1'b1;
    @(negedge clk); ev_wr_done = 1'b0;
  endtask
  task automatic query(input string req, input logic [10:0] a, input logic exp);
    tgt_addr = a; #0.5;
    check(req, addr_ok, exp);
  endtask

  task automatic t_reset_state();
    check("R11 power-up status", status_o, 8'h00);
    check("R1 status idle", status_o, 8'h00);
    check("R2 no latch no write", addr_ok, 0);
  endtask

  task automatic t_wren_len();
    wren(6'd7);  check("R4 short frame", status_o, 8'h00);
    wren(6'd9);  check("R4 long frame", status_o, 8'h00);
    wren(6'd8);  check("R3 exact frame", status_o, 8'h02);
    wren(6'd5);  check("R4 latch kept", status_o, 8'h02);
  endtask

  task automatic t_wrdi();
    wrdi(); check("R5 wrdi clears", status_o, 8'h00);
    @(negedge clk); ev_wren = 1'b1; ev_wrdi = 1'b1; wren_bits = 6'd8;
    @(negedge clk); ev_wren = 1'b0; ev_wrdi = 1'b0;
    check("R5 wrdi wins", status_o, 8'h00);
  endtask

  task automatic t_array_write();
    wren(6'd8);
    commit(11'h123);
    check("R6 go pulse", array_wr_go, 1);
    check("R6 busy set latch clear", status_o, 8'h01);
    @(negedge clk);
    check("R6 go one cycle", array_wr_go, 0);
    done();
    check("R10 done clears busy", status_o, 8'h00);
  endtask

  task automatic t_rejects();
    commit(11'h010);
    check("R7 no latch no go", array_wr_go, 0);
    check("R7 no latch status", status_o, 8'h00);
    wren(6'd8); commit(11'h010);
    wren(6'd8);
    check("R5 latch settable while busy", status_o, 8'h03);
    commit(11'h020);
    check("R7 busy no go", array_wr_go, 0);
    check("R7 busy status kept", status_o, 8'h03);
    done();
    check("R10 done", status_o, 8'h02);
    wrdi();
  endtask

  task automatic t_wrsr_and_decode();
    wren(6'd8); wrsr(8'hFF);
    check("R8 load and ignore bits", status_o, 8'h8D);
    check("R1 read during busy", status_o[0], 1);
    done(); check("R8 after done", status_o, 8'h8C);
    wren(6'd8);
    query("R2 code11 low", 11'h000, 0);
    query("R2 code11 high", 11'h7FF, 0);
    wrsr(8'h04); done(); wren(6'd8);
    check("R8 code01", status_o, 8'h06);
    query("R2 code01 free edge", 11'h5FF, 1);
    query("R2 code01 fence edge", 11'h600, 0);
    query("R2 code01 top", 11'h7FF, 0);
    commit(11'h600);
    check("R7 fenced no go", array_wr_go, 0);
    check("R7 fenced latch kept", status_o, 8'h06);
    wrsr(8'h08); done(); wren(6'd8);
    query("R2 code10 free edge", 11'h3FF, 1);
    query("R2 code10 fence edge", 11'h400, 0);
    wrsr(8'h00); done(); wren(6'd8);
    query("R2 code00 top", 11'h7FF, 1);
    wrdi();
  endtask

  task automatic t_hw_lock();
    wren(6'd8); wrsr(8'h80); done();
    check("R8 enable bit set", status_o, 8'h80);
    lock_pin_n = 1'b0;
    wren(6'd8);
    check("R9 locked stat_ok", stat_ok, 0);
    wrsr(8'h0C);
    check("R9 locked no change", status_o, 8'h82);
    lock_pin_n = 1'b1; #0.5;
    check("R9 pin high allows", stat_ok, 1);
    wrsr(8'h00);
    check("R9 write with pin high", status_o, 8'h01);
    done();
    lock_pin_n = 1'b0;
    wren(6'd8);
    check("R9 enable off allows", stat_ok, 1);
    wrdi();
    lock_pin_n = 1'b1;
  endtask

  task automatic t_busy_pin();
    wren(6'd8); wrsr(8'h84);
    lock_pin_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 busy across pin fall", status_o, 8'h85);
    done();
    check("R10 write kept", status_o, 8'h84);
    lock_pin_n = 1'b1;
  endtask

  task automatic t_reset_keep();
    wren(6'd8); commit(11'h001);
    check("R6 busy before reset", status_o, 8'h85);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset keeps retained bits", status_o, 8'h84);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_wren_len();
    t_wrdi();
    t_array_write();
    t_rejects();
    t_wrsr_and_decode();
    t_hw_lock();
    t_busy_pin();
    t_reset_keep();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule